// File: doc/BRIEF.md
# Three-wire serial register-access slave

This block is a slave on a three-wire serial link made of a transfer-enable line, a serial clock and one bidirectional data line, which the block presents as a separate input, output and output enable. It holds two storage spaces: a small bank of clock/calendar registers, which are plain storage here, and a 24-byte scratch RAM. The block runs on its own system clock. It passes the three serial inputs through a synchronizer and finds the serial clock edges by comparing the synchronized serial clock with its value one cycle earlier.

Each transfer opens when the enable line goes high. The first eight serial clocks shift in a command byte that gives the validity bit, the space, the address, the direction and whether the transfer is a burst. After the command, the host either shifts one byte in (or a run of bytes in burst mode), or clocks the selected data out. Dropping the enable line ends any transfer at once.

Top module: `ser3w_slave`

## Requirements
- R1: Nothing is accessed while the enable input is low. Lowering it at any point returns the block to idle, clears the bit count and drops the output enable. A write byte that has not received all 8 bits is never stored.
- R2: Serial input bits are sampled on rising serial-clock edges. The command byte arrives least significant bit first. If command bit 7 is 0, the transfer performs no write and never drives the data line.
- R3: Command bit 6 selects the space: 0 is the clock/calendar bank (8 registers, addresses 0 to 7) and 1 is the scratch RAM (24 bytes, addresses 0 to 23). The two spaces do not alias.
- R4: Command bits 5..1 hold the byte address. Command bit 0 set to 0 makes the transfer a write and set to 1 makes it a read.
- R5: A single-byte write stores the 8 data bits that follow the command, least significant bit first. Any serial clocks after those bits are ignored until the enable line drops.
- R6: During a read, each data bit (least significant bit first) appears on the output after a falling serial-clock edge. The output enable rises only on such an edge and is high only while read data is being driven. It is low during the command byte.
- R7: An address field of all ones (31) selects burst mode. The byte address starts at 0 and advances by one after every 8 data bits, for both reads and writes.
- R8: Writes to addresses outside the selected space (RAM 24 to 30, clock registers 8 to 30, burst bytes past the end of a space) change nothing. Reads from those addresses return 0.
- R9: After reset, every storage byte reads 0 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_en_i | input | 1 | Transfer enable line; high while a transfer is open |
| sck_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data from the host |
| sdio_o | output | 1 | Serial read data to the host |
| sdio_oe_o | output | 1 | High while the block drives the data line |

## Verification
A corrupted bit counter or phase register misaligns every byte that follows. The first readback then returns the written value rotated, or returns data from the neighbouring address, so the fault appears within a single write-read pair. An enable that is not cleared by an abort appears as a high output enable on the cycle after the synchronized enable falls. A wrong burst address shows up in the first byte of a burst readback, and a missing range check shows up as a non-zero read from an unused address.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
    localparam int CMD_W  = 8;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_RD_LAST,
        ST_HALT
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  bcnt;
        logic [CMD_W-1:0]  sh;
        logic              space;
        logic [ADDR_W-1:0] addr;
        logic              burst;
        logic [DATA_W-1:0] tx;
        logic              out;
        logic              oe;
        logic              sck_prev;
    } core_t;
endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_comb stg_d[g] = d_i;
            end else begin : g_next
                always_comb stg_d[g] = stg_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ser3w_regbank.sv
module ser3w_regbank #(
    parameter int CLK_REGS  = 8,
    parameter int RAM_BYTES = 24,
    parameter int AW        = 5,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          wspace_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rspace_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] clk_q [CLK_REGS];
    logic [DW-1:0] clk_d [CLK_REGS];
    logic [DW-1:0] ram_q [RAM_BYTES];
    logic [DW-1:0] ram_d [RAM_BYTES];

    always_comb begin
        for (int i = 0; i < CLK_REGS; i++) begin
            clk_d[i] = clk_q[i];
            if (we_i && !wspace_i && waddr_i == AW'(i)) clk_d[i] = wdata_i;
        end
        for (int i = 0; i < RAM_BYTES; i++) begin
            ram_d[i] = ram_q[i];
            if (we_i && wspace_i && waddr_i == AW'(i)) ram_d[i] = wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < CLK_REGS; i++)
            if (!rspace_i && raddr_i == AW'(i)) rdata_o = clk_q[i];
        for (int i = 0; i < RAM_BYTES; i++)
            if (rspace_i && raddr_i == AW'(i)) rdata_o = ram_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CLK_REGS; i++)  clk_q[i] <= '0;
            for (int i = 0; i < RAM_BYTES; i++) ram_q[i] <= '0;
        end else begin
            for (int i = 0; i < CLK_REGS; i++)  clk_q[i] <= clk_d[i];
            for (int i = 0; i < RAM_BYTES; i++) ram_q[i] <= ram_d[i];
        end
    end
endmodule

// File: rtl/ser3w_slave.sv
module ser3w_slave
    import ser3w_pkg::*;
#(
    parameter int CLK_REGS    = 8,
    parameter int RAM_BYTES   = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_en_i,
    input  logic sck_i,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe_o
);
    localparam logic [ADDR_W-1:0] BURST_ADDR = '1;
    localparam logic [CNT_W-1:0]  LAST_BIT   = CNT_W'(DATA_W - 1);

    logic [2:0] sync_s;
    logic       en_s, sck_s, din_s, sck_rise, sck_fall;
    core_t      q, d;
    logic       we;
    logic [DATA_W-1:0] wdata, rdata, rbyte;

    ser3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({xfer_en_i, sck_i, sdio_i}),
        .q_o  (sync_s)
    );

    assign {en_s, sck_s, din_s} = sync_s;
    assign sck_rise = sck_s & ~q.sck_prev;
    assign sck_fall = ~sck_s & q.sck_prev;

    ser3w_regbank #(
        .CLK_REGS (CLK_REGS),
        .RAM_BYTES(RAM_BYTES),
        .AW       (ADDR_W),
        .DW       (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .wspace_i(q.space),
        .waddr_i (q.addr),
        .wdata_i (wdata),
        .rspace_i(q.space),
        .raddr_i (q.addr),
        .rdata_o (rdata)
    );

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
        return (a == BURST_ADDR) ? a : a + 1'b1;
    endfunction

    always_comb begin
        d          = q;
        d.sck_prev = sck_s;
        we         = 1'b0;
        wdata      = {din_s, q.sh[CMD_W-1:1]};
        rbyte      = (q.bcnt == '0) ? rdata : q.tx;
        if (!en_s) begin
            d.st   = ST_IDLE;
            d.bcnt = '0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                ST_IDLE, ST_CMD: begin
                    d.st = ST_CMD;
                    if (sck_rise) begin
                        d.sh   = {din_s, q.sh[CMD_W-1:1]};
                        d.bcnt = q.bcnt + 1'b1;
                        if (q.bcnt == LAST_BIT) begin
                            d.bcnt  = '0;
                            d.space = d.sh[6];
                            d.burst = (d.sh[5:1] == BURST_ADDR);
                            d.addr  = d.burst ? '0 : d.sh[5:1];
                            if (!d.sh[7])     d.st = ST_HALT;
                            else if (d.sh[0]) d.st = ST_RD;
                            else              d.st = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (sck_rise) begin
                        d.sh   = wdata;
                        d.bcnt = q.bcnt + 1'b1;
                        if (q.bcnt == LAST_BIT) begin
                            we = 1'b1;
                            if (q.burst) d.addr = next_addr(q.addr);
                            else         d.st   = ST_HALT;
                        end
                    end
                end
                ST_RD: begin
                    if (sck_fall) begin
                        d.out  = rbyte[0];
                        d.tx   = rbyte >> 1;
                        d.oe   = 1'b1;
                        d.bcnt = q.bcnt + 1'b1;
                        if (q.bcnt == LAST_BIT) begin
                            if (q.burst) d.addr = next_addr(q.addr);
                            else         d.st   = ST_RD_LAST;
                        end
                    end
                end
                ST_RD_LAST: begin
                    if (sck_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_HALT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sdio_o    = q.out;
    assign sdio_oe_o = q.oe;
endmodule

// File: rtl/ser3w_slave_chk.sv
module ser3w_slave_chk
    import ser3w_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic en_s,
    input logic sck_rise,
    input logic sck_fall,
    input logic we,
    input logic sdio_o,
    input logic sdio_oe_o,
    input st_e  st
);
    p_release_on_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> !sdio_oe_o);

    p_no_access_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT) |-> !we);

    p_write_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> sck_rise);

    p_out_moves_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && !sck_fall) |=> $stable(sdio_o));

    p_oe_only_reading_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe_o |-> (st == ST_RD || st == ST_RD_LAST));

    p_oe_rises_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe_o) |-> $past(sck_fall));
endmodule

bind ser3w_slave ser3w_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_s     (en_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .we       (we),
    .sdio_o   (sdio_o),
    .sdio_oe_o(sdio_oe_o),
    .st       (q.st)
);

// File: tb/tb_ser3w_slave.sv
module tb_ser3w_slave;
    localparam int H = 6;
    localparam int NV = 8;
    // {write cmd, write data, read cmd, expected}
    localparam logic [31:0] VEC [NV] = '{
        32'h82_3C_83_3C,  // R3 R4 clock reg 1
        32'hCA_A5_CB_A5,  // R3 R4 RAM 5
        32'h8A_11_CB_A5,  // R3 clock 5 does not touch RAM 5
        32'hEE_7E_EF_7E,  // R3 last RAM byte 23
        32'hF0_FF_F1_00,  // R8 RAM 24 unused
        32'h92_77_93_00,  // R8 clock 9 unused
        32'h4C_99_CD_00,  // R2 bit7 clear: no write to RAM 6
        32'h80_01_8B_11   // R3 clock 5 kept
    };

    logic clk = 0, rst_n = 0, en = 0, sck = 0, sdi = 0;
    logic sdo, oe;
    int   checks = 0, fails = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    ser3w_slave dut (
        .clk(clk), .rst_n(rst_n), .xfer_en_i(en), .sck_i(sck),
        .sdio_i(sdi), .sdio_o(sdo), .sdio_oe_o(oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic b, output logic rb);
        sck = 0; sdi = b; wt(H);
        rb = sdo;
        sck = 1; wt(H);
    endtask

    task automatic open_x();
        sck = 0; en = 1; wt(H);
    endtask

    task automatic close_x();
        sck = 0; wt(H); en = 0; wt(H);
    endtask

    task automatic send(input logic [7:0] b);
        logic rb;
        for (int i = 0; i < 8; i++) bit_xfer(b[i], rb);
    endtask

    task automatic recv(output logic [7:0] b);
        logic rb;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(1'b0, rb);
            b[i] = rb;
        end
    endtask

    task automatic wr1(input logic [7:0] c, input logic [7:0] v);
        open_x(); send(c); send(v); close_x();
    endtask

    task automatic rd1(input logic [7:0] c, output logic [7:0] v);
        open_x(); send(c); recv(v); close_x();
    endtask

    initial begin
        for (int n = 0; n < 200000 && !done; n++) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic rb;
        wt(4); rst_n = 1; wt(4);

        // R9 reset state
        chk("R9 oe after reset", {7'd0, oe}, 8'h00);
        rd1(8'hC1, v); chk("R9 RAM0 after reset", v, 8'h00);
        rd1(8'h8F, v); chk("R9 clock7 after reset", v, 8'h00);

        // vector table
        for (int k = 0; k < NV; k++) begin
            wr1(VEC[k][31:24], VEC[k][23:16]);
            rd1(VEC[k][15:8], v);
            chk($sformatf("R3/R4/R8/R2 vector %0d", k), v, VEC[k][7:0]);
        end

        // R6 output enable timing within a read
        open_x(); send(8'hCB);
        chk("R6 oe low after command", {7'd0, oe}, 8'h00);
        recv(v);
        chk("R6 read data RAM5", v, 8'hA5);
        chk("R6 oe high on last bit", {7'd0, oe}, 8'h01);
        close_x();
        chk("R6 oe low after read", {7'd0, oe}, 8'h00);

        // R2 invalid command read never drives
        open_x(); send(8'h4B); recv(v);
        chk("R2 no drive on invalid read", {7'd0, oe}, 8'h00);
        close_x();

        // R1 abort mid-write discards partial byte
        open_x(); send(8'hC2);
        for (int i = 0; i < 4; i++) bit_xfer(1'b1, rb);
        close_x();
        rd1(8'hC3, v); chk("R1 partial write discarded", v, 8'h00);

        // R1 abort mid-read releases line
        open_x(); send(8'hCB);
        for (int i = 0; i < 3; i++) bit_xfer(1'b0, rb);
        chk("R1 oe high mid-read", {7'd0, oe}, 8'h01);
        close_x();
        chk("R1 oe low after abort", {7'd0, oe}, 8'h00);
        rd1(8'hCB, v); chk("R1 clean read after abort", v, 8'hA5);

        // R5 extra clocks after single write ignored
        open_x(); send(8'hC4); send(8'h12); send(8'hFF); close_x();
        rd1(8'hC5, v); chk("R5 single write value", v, 8'h12);
        rd1(8'hC7, v); chk("R5 next address untouched", v, 8'h00);

        // R7 burst RAM write then read
        open_x(); send(8'hFE);
        for (int i = 0; i < 24; i++) send(8'(i * 7 + 3));
        close_x();
        open_x(); send(8'hFF);
        for (int i = 0; i < 24; i++) begin
            recv(v);
            chk($sformatf("R7 burst RAM byte %0d", i), v, 8'(i * 7 + 3));
        end
        close_x();

        // R7 R8 burst clock space, past end reads zero
        open_x(); send(8'hBE);
        for (int i = 0; i < 9; i++) send(8'(8'hF0 + i));
        close_x();
        open_x(); send(8'hBF);
        for (int i = 0; i < 8; i++) begin
            recv(v);
            chk($sformatf("R7 burst clock byte %0d", i), v, 8'(8'hF0 + i));
        end
        recv(v); chk("R8 burst past clock bank", v, 8'h00);
        close_x();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule